// File: doc/BRIEF.md
# Interrupt CPU Target Register Bank

This block keeps one 8-bit CPU target mask per shared interrupt and turns each mask into a single routed CPU index, which is offered on a wide output bus for the delivery logic next to it. Software reaches the masks through a simple register port. Each interrupt owns exactly one byte of the address window, so the byte address of an access is the interrupt ID. An access is either one byte or one aligned 32-bit word that covers four consecutive IDs.

The first 32 IDs are private to each CPU and cannot be retargeted. Writes to them are dropped, and a read of them reports the requesting CPU as a one-hot mask. Every stored byte is cut down to the CPUs that are online, and IDs at or above the configured interrupt count behave as empty space.

Top module: `irq_target_bank`

## Requirements
- R1: After a synchronous active-high reset, every stored mask is zero, every routed CPU index is 0 and rd_data is zero.
- R2: A byte write (acc_size32=0) stores acc_wdata[7:0], after clipping, into the entry whose ID equals acc_addr. No other entry changes.
- R3: A 32-bit write (acc_size32=1) addresses the aligned word at acc_addr with bits 1:0 cleared. Byte lane k (acc_wdata[8k+7:8k]) goes to ID base+k, and a 32-bit read returns ID base+k in the same lane.
- R4: A written byte is ANDed with a mask of the online CPUs before it is stored. For online_cpus = n with n below 8 that mask is bits 0..n-1 (n = 0 gives an all-zero mask), and for n of 8 or more it is all ones.
- R5: Writes to IDs 0..31 are ignored. A read of any of those IDs returns 1 << req_cpu in that ID's lane.
- R6: The routed CPU index of an entry is the position of the lowest set bit of its stored mask, and it changes in the cycle after the write clock edge, not before.
- R7: An entry whose stored mask is zero routes to CPU 0.
- R8: IDs at or above NUM_IRQ read as zero and ignore writes, including the upper lanes of a 32-bit word that is only partly inside the range.
- R9: Read data is registered. It appears on rd_data after the clock edge that takes the read. A byte read returns the value in rd_data[7:0] with the upper 24 bits zero.
- R10: The route_cpu fields of the private IDs 0..31 are always 0. Field i is route_cpu[3i+2:3i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| online_cpus | input | 4 | Number of CPUs that are online |
| req_cpu | input | 3 | Index of the CPU making the access |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_size32 | input | 1 | 1 for a 32-bit word, 0 for a single byte |
| acc_addr | input | ADDR_W | Byte address, which equals the interrupt ID |
| acc_wdata | input | 32 | Write data; a byte write uses bits 7:0 |
| rd_data | output | 32 | Registered read data |
| route_cpu | output | 3*NUM_IRQ | Routed CPU index for each interrupt |

## Verification
The hardest case to reach is the last word of the ID range when NUM_IRQ is not a multiple of four. In that word one 32-bit access mixes stored lanes with lanes that must stay empty. The default count of 62 is chosen to produce this case, and the bench writes and reads that word as a whole. The bench also changes online_cpus between writes, including values of 0 and above 8, so that clipping is seen to act at write time on each byte lane and not at read time.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    localparam int CPU_W    = 3;
    localparam int PRIV_IRQ = 32;
    localparam int LANES    = 4;

    typedef logic [7:0]       cpu_mask_t;
    typedef logic [CPU_W-1:0] cpu_idx_t;

    typedef struct packed {
        logic       is_wr;
        logic       is_rd;
        logic       size32;
        logic [3:0] lane_en;
        logic [1:0] lane_sel;
    } acc_ctl_t;

    function automatic cpu_mask_t online_mask(input logic [3:0] n);
        logic [8:0] t;
        if (n >= 4'd8) return 8'hFF;
        t = (9'd1 << n) - 9'd1;
        return t[7:0];
    endfunction

    function automatic cpu_idx_t lowest_set(input cpu_mask_t m);
        cpu_idx_t r;
        r = '0;
        for (int i = 7; i >= 0; i--)
            if (m[i]) r = cpu_idx_t'(i);
        return r;
    endfunction

    function automatic cpu_mask_t onehot_cpu(input cpu_idx_t c);
        return 8'd1 << c;
    endfunction

endpackage

// File: rtl/tgt_access_decode.sv
module tgt_access_decode
    import tgt_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic                  acc_size32,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [31:0]           acc_wdata,
    output acc_ctl_t              ctl,
    output logic [WORD_W-1:0]     word,
    output cpu_mask_t [LANES-1:0] lane_wdata
);

    always_comb begin
        ctl.is_wr    = acc_valid && acc_write;
        ctl.is_rd    = acc_valid && !acc_write;
        ctl.size32   = acc_size32;
        ctl.lane_sel = acc_addr[1:0];
        ctl.lane_en  = acc_size32 ? 4'b1111 : (4'b0001 << acc_addr[1:0]);
        word         = acc_addr[ADDR_W-1:2];
    end

    // A byte access carries its data in the low byte; steer it to every lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_wdata[k] = acc_size32 ? acc_wdata[8*k +: 8] : acc_wdata[7:0];
    end

endmodule

// File: rtl/tgt_entry.sv
module tgt_entry
    import tgt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  cpu_mask_t wbyte,
    input  cpu_mask_t cmask,
    output cpu_mask_t mask_q,
    output cpu_idx_t  route_q
);

    cpu_mask_t clipped;
    assign clipped = wbyte & cmask;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            route_q <= '0;
        end else if (we) begin
            mask_q  <= clipped;
            route_q <= lowest_set(clipped);
        end
    end

    // R4: nothing outside the online set survives a write
    p_clip_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> ((mask_q & ~$past(cmask)) == 8'd0));

    // R2: an entry holds its value without a write
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mask_q));

    // R6: route points at a set bit with nothing set below it
    p_route_low_r6: assert property (@(posedge clk) disable iff (rst)
        (mask_q != 8'd0) |-> (mask_q[route_q] &&
                              ((mask_q & ((8'd1 << route_q) - 8'd1)) == 8'd0)));

    // R7: empty mask routes to CPU 0
    p_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 8'd0) |-> (route_q == '0));

endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank
    import tgt_pkg::*;
#(
    parameter int NUM_IRQ = 62,
    parameter int ADDR_W  = 10,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             online_cpus,
    input  logic [2:0]             req_cpu,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic                   acc_size32,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [31:0]            acc_wdata,
    output logic [31:0]            rd_data,
    output logic [NUM_IRQ*3-1:0]   route_cpu
);

    acc_ctl_t              ctl;
    logic [WORD_W-1:0]     word;
    cpu_mask_t [LANES-1:0] lane_wdata;
    cpu_mask_t             cmask;
    cpu_mask_t             mask_arr [NUM_IRQ];
    cpu_mask_t [LANES-1:0] lane_rd;
    logic [31:0]           rd_next;

    assign cmask = online_mask(online_cpus);

    tgt_access_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_size32(acc_size32),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .ctl       (ctl),
        .word      (word),
        .lane_wdata(lane_wdata)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        if (i < PRIV_IRQ) begin : g_priv
            assign mask_arr[i]         = '0;
            assign route_cpu[3*i +: 3] = '0;
        end else begin : g_shared
            localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(i / LANES);
            localparam int                MY_LANE = i % LANES;
            logic we;
            assign we = ctl.is_wr && (word == MY_WORD) && ctl.lane_en[MY_LANE];
            tgt_entry u_ent (
                .clk    (clk),
                .rst    (rst),
                .we     (we),
                .wbyte  (lane_wdata[MY_LANE]),
                .cmask  (cmask),
                .mask_q (mask_arr[i]),
                .route_q(route_cpu[3*i +: 3])
            );
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rdlane
        logic [ADDR_W-1:0] lid;
        assign lid = {word, 2'(k)};
        always_comb begin
            lane_rd[k] = '0;
            if (lid < ADDR_W'(PRIV_IRQ)) begin
                lane_rd[k] = onehot_cpu(req_cpu);
            end else begin
                for (int j = PRIV_IRQ; j < NUM_IRQ; j++)
                    if (lid == ADDR_W'(j)) lane_rd[k] = mask_arr[j];
            end
        end
    end

    assign rd_next = ctl.size32 ? lane_rd : {24'd0, lane_rd[ctl.lane_sel]};

    always_ff @(posedge clk) begin
        if (rst)            rd_data <= '0;
        else if (ctl.is_rd) rd_data <= rd_next;
    end

    // R8: a byte read beyond the range returns zero
    p_oob_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !acc_size32 && (acc_addr >= ADDR_W'(NUM_IRQ)))
        |=> (rd_data == 32'd0));

    // R5: a byte read of a private ID returns the requester one-hot
    p_priv_read_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !acc_size32 && (acc_addr < ADDR_W'(PRIV_IRQ)))
        |=> (rd_data == {24'd0, 8'd1 << $past(req_cpu)}));

    // R9: rd_data only moves after a read
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> $stable(rd_data));

endmodule

// File: tb/test_irq_target_bank.sv
`timescale 1ns/1ps
module test_irq_target_bank;

    localparam int NUM_IRQ = 62;
    localparam int ADDR_W  = 10;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [3:0]            online_cpus = 4'd4;
    logic [2:0]            req_cpu = 3'd2;
    logic                  acc_valid = 1'b0;
    logic                  acc_write = 1'b0;
    logic                  acc_size32 = 1'b0;
    logic [ADDR_W-1:0]     acc_addr = '0;
    logic [31:0]           acc_wdata = '0;
    logic [31:0]           rd_data;
    logic [NUM_IRQ*3-1:0]  route_cpu;

    int checks = 0;
    int errors = 0;
    logic [7:0]  model [NUM_IRQ];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    irq_target_bank #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) i_irq_target_bank (
        .clk(clk), .rst(rst), .online_cpus(online_cpus), .req_cpu(req_cpu),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_size32(acc_size32),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .route_cpu(route_cpu)
    );

    function automatic logic [7:0] allowed(input logic [3:0] n);
        if (n > 4'd7) return 8'hFF;
        return 8'((16'd1 << n) - 16'd1);
    endfunction

    function automatic logic [2:0] first_cpu(input logic [7:0] m);
        for (int b = 0; b < 8; b++) if (m[b]) return 3'(b);
        return 3'd0;
    endfunction

    function automatic logic [7:0] read_model(input int id);
        if (id < 32) return 8'd1 << req_cpu;
        if (id < NUM_IRQ) return model[id];
        return 8'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_route(input string req, input int id);
        check(req, 32'(route_cpu[3*id +: 3]),
              (id < 32) ? 32'd0 : 32'(first_cpu(model[id])));
    endtask

    task automatic do_write(input logic s32, input int addr, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_size32 = s32;
        acc_addr = ADDR_W'(addr); acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        if (s32) begin
            for (int k = 0; k < 4; k++) begin
                int id;
                id = (addr & ~3) + k;
                if (id >= 32 && id < NUM_IRQ) model[id] = d[8*k +: 8] & allowed(online_cpus);
            end
        end else if (addr >= 32 && addr < NUM_IRQ) begin
            model[addr] = d[7:0] & allowed(online_cpus);
        end
    endtask

    task automatic do_read(input logic s32, input int addr, input string req);
        logic [31:0] e;
        if (s32) begin
            for (int k = 0; k < 4; k++) e[8*k +: 8] = read_model((addr & ~3) + k);
        end else begin
            e = {24'd0, read_model(addr)};
        end
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_size32 = s32;
        acc_addr = ADDR_W'(addr);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Monitor: each read taken at a clock edge yields one registered result.
    always @(posedge clk) begin
        if (!rst && acc_valid && !acc_write) begin
            #1;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 actual=%h expected=<none queued>", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_IRQ; i++) model[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_data", rd_data, 32'd0);
        for (int i = 32; i < NUM_IRQ; i++) check_route("R1 route", i);
        do_read(1'b1, 40, "R1 read after reset");

        // R2 / R6: byte write, route changes only after the edge
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_size32 = 1'b0;
        acc_addr = ADDR_W'(33); acc_wdata = 32'h0000_000C;
        #1 check("R6 before edge", 32'(route_cpu[3*33 +: 3]), 32'd0);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        model[33] = 8'h0C;
        check_route("R6 after edge", 33);
        do_read(1'b0, 33, "R2 byte readback");
        check_route("R2 neighbour 34", 34);

        // R3 / R4 / R7: word write with clipping to 4 CPUs
        do_write(1'b1, 37, 32'hF081_0600);
        do_read(1'b1, 36, "R3 word lanes");
        check_route("R7 empty 36", 36);
        check_route("R6 lane 37", 37);
        check_route("R4 clipped 38", 38);
        check_route("R4 clipped 39", 39);

        // R4: 8 online, then more than 8, then none
        online_cpus = 4'd8;
        do_write(1'b0, 39, 32'h80);
        check_route("R6 cpu7", 39);
        online_cpus = 4'd11;
        do_write(1'b0, 40, 32'hFF);
        do_read(1'b0, 40, "R4 above 8 online");
        online_cpus = 4'd0;
        do_write(1'b0, 45, 32'hFF);
        do_read(1'b0, 45, "R4 none online");
        check_route("R7 none online", 45);
        online_cpus = 4'd8;

        // R5 / R10: private IDs
        do_write(1'b0, 5, 32'hFF);
        do_write(1'b1, 28, 32'hFFFF_FFFF);
        do_read(1'b0, 5, "R5 private byte");
        req_cpu = 3'd5;
        do_read(1'b1, 28, "R5 private word");
        check_route("R10 private 5", 5);
        check_route("R10 private 30", 30);

        // R8: last word straddles NUM_IRQ, and far beyond it
        do_write(1'b1, 60, 32'h4433_2211);
        do_read(1'b1, 60, "R8 partial word");
        do_read(1'b0, 63, "R8 byte beyond");
        do_write(1'b0, 500, 32'h0F);
        do_read(1'b0, 500, "R8 far beyond");
        check_route("R8 lane 61", 61);

        // R9: byte read returns in low byte
        do_read(1'b0, 38, "R9 low byte");
        do_read(1'b0, 61, "R9 low byte 61");

        // R7: overwrite with zero
        do_write(1'b0, 33, 32'h00);
        check_route("R7 cleared 33", 33);

        for (int i = 0; i < NUM_IRQ; i++) check_route("R2 final sweep", i);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R9 actual=%0d expected=0 results outstanding", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule